// File: doc/BRIEF.md
# Per-Thread In-Flight Address Tracker

This block keeps a small table of memory accesses that are still in flight, one row per request slot. Each row holds the owning hardware thread, the address and the sequence number of the instruction that asked for it. A new request from a thread is granted a slot only when three conditions hold: that thread is not halted by a translation fault, that thread does not already hold a row with the same address, and a row is free. Grant or deny is decided in the same cycle from the table as it stood at the start of that cycle. The granted row is written at the next clock edge.

Rows leave the table in two ways. The pipeline frees a slot explicitly. A squash of a thread marks every younger row of that thread as squashed. A squashed row with no memory access pending and no translation stall is dropped at once. Otherwise it stays, and still blocks its address, until the memory response or the end of the translation stall releases it. A translation stall recorded against a row halts all requests from its thread. When the block serves the instruction-fetch side, the parameter `FETCH_PORT` turns the same-address check off, and only free capacity matters.

Top module: `addr_inflight_tracker`

## Requirements
- R1: After reset the table is empty and no thread is halted, so the first request is granted slot 0.
- R2: A request is granted the lowest-numbered empty slot (`req_grant`=1, `req_deny`=0, `req_slot`=index) when it is neither halted nor in conflict and a slot is empty. Otherwise `req_deny`=1 and `req_slot`=0. A full table denies every request. With `req_valid`=0 both `req_grant` and `req_deny` are 0.
- R3: With `FETCH_PORT`=0, a request is denied when a row of the same thread holds the identical address. This includes rows that are squashed but still held. The same address from another thread is granted.
- R4: With `FETCH_PORT`=1 the address check is skipped, so repeated requests to one address from one thread are granted while slots remain.
- R5: `xstall_set` on an occupied slot halts that row's thread, and every request of a halted thread is denied. `xstall_clr` on a row holding a stall clears the stall and releases the thread.
- R6: `free_valid` empties the named slot at the next edge. If the same slot is granted in that cycle, the free wins and the slot ends empty.
- R7: A squash of thread T with boundary N marks every row of T whose sequence number is greater than N as squashed. N is `kill_seq`, or `kill_seq`+1 when `kill_memstall`=1. A squashed row with no access pending and no translation stall is emptied at once. Rows granted in the squash cycle are not affected.
- R8: `issue_valid` marks an occupied row as having an access pending. `resp_valid` clears that mark. A squashed row that is still pending stays in the table until its response, and that response empties it when no stall is held. A response to a row that is not squashed only clears the pending mark.
- R9: Squashing a row that holds a translation stall releases its thread at once. The row itself stays until `xstall_clr` on it, which empties it when no access is pending.
- R10: Sequence numbers are unsigned 16-bit values compared without wraparound. A squash at boundary 0xFFFF+1 squashes nothing, and a row with sequence 0 is never younger than 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request this cycle |
| req_tid | input | TID_W | Requesting thread |
| req_addr | input | ADDR_W | Requested address |
| req_seq | input | SEQ_W | Sequence number of the requester |
| req_grant | output | 1 | Request granted |
| req_deny | output | 1 | Request refused |
| req_slot | output | SLOT_W | Granted slot, 0 when not granted |
| free_valid | input | 1 | Release a slot |
| free_slot | input | SLOT_W | Slot to release |
| issue_valid | input | 1 | Memory access issued for a slot |
| issue_slot | input | SLOT_W | Slot whose access was issued |
| resp_valid | input | 1 | Memory response for a slot |
| resp_slot | input | SLOT_W | Slot whose response arrived |
| xstall_set | input | 1 | Translation fault stalls a slot |
| xstall_set_slot | input | SLOT_W | Slot that faulted |
| xstall_clr | input | 1 | Translation stall of a slot ends |
| xstall_clr_slot | input | SLOT_W | Slot whose stall ends |
| kill_valid | input | 1 | Squash request |
| kill_tid | input | TID_W | Thread to squash |
| kill_seq | input | SEQ_W | Squash boundary |
| kill_memstall | input | 1 | Squash caused by a memory stall (boundary +1) |

## Verification
The hardest case to reach is a squashed row that must linger because a memory access is still pending or a translation stall is held on it. To get there, a row has to be granted, marked pending or stalled, and then squashed by sequence number. Its continued presence can only be seen as a denial of a repeat request to the same address. Directed sequences build exactly these orderings, including the memory-stall boundary and the top of the 16-bit sequence range. Long random runs over a small set of addresses and threads then make conflicts, full tables and coincident free, response, stall and squash events frequent. A bench model computes the expected grant and slot for every cycle.

// File: rtl/atrk_pkg.sv
package atrk_pkg;

    typedef struct packed {
        logic valid;
        logic pend;
        logic tstall;
        logic sq;
    } slot_flags_t;

    localparam slot_flags_t FLAGS_EMPTY = '{valid: 1'b0, pend: 1'b0, tstall: 1'b0, sq: 1'b0};
    localparam slot_flags_t FLAGS_NEW   = '{valid: 1'b1, pend: 1'b0, tstall: 1'b0, sq: 1'b0};

endpackage

// File: rtl/atrk_match.sv
module atrk_match #(
    parameter int NUM_SLOTS  = 8,
    parameter int TID_W      = 2,
    parameter int ADDR_W     = 32,
    parameter bit FETCH_PORT = 1'b0
) (
    input  logic [NUM_SLOTS-1:0]             busy,
    input  logic [NUM_SLOTS-1:0][TID_W-1:0]  row_tid,
    input  logic [NUM_SLOTS-1:0][ADDR_W-1:0] row_addr,
    input  logic [TID_W-1:0]                 q_tid,
    input  logic [ADDR_W-1:0]                q_addr,
    output logic                             conflict
);
    generate
        if (FETCH_PORT) begin : g_fetch
            assign conflict = 1'b0;
        end else begin : g_data
            logic [NUM_SLOTS-1:0] hit;
            for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
                assign hit[i] = busy[i] && (row_tid[i] == q_tid) && (row_addr[i] == q_addr);
            end
            assign conflict = |hit;
        end
    endgenerate
endmodule

// File: rtl/atrk_pick.sv
module atrk_pick #(
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [NUM_SLOTS-1:0] busy,
    output logic                 found,
    output logic [SLOT_W-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/atrk_squash_sel.sv
module atrk_squash_sel #(
    parameter int NUM_SLOTS = 8,
    parameter int TID_W     = 2,
    parameter int SEQ_W     = 16
) (
    input  logic                            kill_valid,
    input  logic [TID_W-1:0]                kill_tid,
    input  logic [SEQ_W-1:0]                kill_seq,
    input  logic                            kill_memstall,
    input  logic [NUM_SLOTS-1:0]            busy,
    input  logic [NUM_SLOTS-1:0][TID_W-1:0] row_tid,
    input  logic [NUM_SLOTS-1:0][SEQ_W-1:0] row_seq,
    output logic [NUM_SLOTS-1:0]            hit
);
    logic [SEQ_W:0] bound;
    assign bound = {1'b0, kill_seq} + {{SEQ_W{1'b0}}, kill_memstall};

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_row
            assign hit[i] = kill_valid && busy[i] && (row_tid[i] == kill_tid)
                            && ({1'b0, row_seq[i]} > bound);
        end
    endgenerate
endmodule

// File: rtl/addr_inflight_tracker.sv
module addr_inflight_tracker
    import atrk_pkg::*;
#(
    parameter int NUM_SLOTS   = 8,
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    parameter int SEQ_W       = 16,
    parameter bit FETCH_PORT  = 1'b0,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SEQ_W-1:0]  req_seq,
    output logic              req_grant,
    output logic              req_deny,
    output logic [SLOT_W-1:0] req_slot,
    input  logic              free_valid,
    input  logic [SLOT_W-1:0] free_slot,
    input  logic              issue_valid,
    input  logic [SLOT_W-1:0] issue_slot,
    input  logic              resp_valid,
    input  logic [SLOT_W-1:0] resp_slot,
    input  logic              xstall_set,
    input  logic [SLOT_W-1:0] xstall_set_slot,
    input  logic              xstall_clr,
    input  logic [SLOT_W-1:0] xstall_clr_slot,
    input  logic              kill_valid,
    input  logic [TID_W-1:0]  kill_tid,
    input  logic [SEQ_W-1:0]  kill_seq,
    input  logic              kill_memstall
);

    typedef struct packed {
        slot_flags_t [NUM_SLOTS-1:0]             fl;
        logic        [NUM_SLOTS-1:0][TID_W-1:0]  tid;
        logic        [NUM_SLOTS-1:0][ADDR_W-1:0] addr;
        logic        [NUM_SLOTS-1:0][SEQ_W-1:0]  seq;
        logic        [NUM_THREADS-1:0]           blk;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] busy_q;
    logic                 conflict;
    logic                 room;
    logic [SLOT_W-1:0]    pick_idx;
    logic [NUM_SLOTS-1:0] kill_hit;
    logic                 grant_d;

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) busy_q[i] = st_q.fl[i].valid;
    end

    atrk_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .TID_W     (TID_W),
        .ADDR_W    (ADDR_W),
        .FETCH_PORT(FETCH_PORT)
    ) u_match (
        .busy    (busy_q),
        .row_tid (st_q.tid),
        .row_addr(st_q.addr),
        .q_tid   (req_tid),
        .q_addr  (req_addr),
        .conflict(conflict)
    );

    atrk_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .busy (busy_q),
        .found(room),
        .idx  (pick_idx)
    );

    atrk_squash_sel #(
        .NUM_SLOTS(NUM_SLOTS),
        .TID_W    (TID_W),
        .SEQ_W    (SEQ_W)
    ) u_squash (
        .kill_valid   (kill_valid),
        .kill_tid     (kill_tid),
        .kill_seq     (kill_seq),
        .kill_memstall(kill_memstall),
        .busy         (busy_q),
        .row_tid      (st_q.tid),
        .row_seq      (st_q.seq),
        .hit          (kill_hit)
    );

    assign grant_d   = req_valid && !st_q.blk[req_tid] && !conflict && room;
    assign req_grant = grant_d;
    assign req_deny  = req_valid && !grant_d;
    assign req_slot  = grant_d ? pick_idx : '0;

    always_comb begin
        st_d = st_q;
        // new row
        if (grant_d) begin
            st_d.fl[pick_idx]   = FLAGS_NEW;
            st_d.tid[pick_idx]  = req_tid;
            st_d.addr[pick_idx] = req_addr;
            st_d.seq[pick_idx]  = req_seq;
        end
        // memory access issued
        if (issue_valid && st_d.fl[issue_slot].valid) begin
            st_d.fl[issue_slot].pend = 1'b1;
        end
        // translation fault halts the thread
        if (xstall_set && st_d.fl[xstall_set_slot].valid) begin
            st_d.fl[xstall_set_slot].tstall     = 1'b1;
            st_d.blk[st_d.tid[xstall_set_slot]] = 1'b1;
        end
        // memory response
        if (resp_valid && st_d.fl[resp_slot].valid) begin
            st_d.fl[resp_slot].pend = 1'b0;
            if (st_d.fl[resp_slot].sq && !st_d.fl[resp_slot].tstall) begin
                st_d.fl[resp_slot] = FLAGS_EMPTY;
            end
        end
        // translation stall ends
        if (xstall_clr && st_d.fl[xstall_clr_slot].valid && st_d.fl[xstall_clr_slot].tstall) begin
            st_d.fl[xstall_clr_slot].tstall     = 1'b0;
            st_d.blk[st_d.tid[xstall_clr_slot]] = 1'b0;
            if (st_d.fl[xstall_clr_slot].sq && !st_d.fl[xstall_clr_slot].pend) begin
                st_d.fl[xstall_clr_slot] = FLAGS_EMPTY;
            end
        end
        // squash of younger rows
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (kill_hit[i] && st_d.fl[i].valid) begin
                st_d.fl[i].sq = 1'b1;
                if (st_d.fl[i].tstall) st_d.blk[st_d.tid[i]] = 1'b0;
                if (!st_d.fl[i].pend && !st_d.fl[i].tstall) st_d.fl[i] = FLAGS_EMPTY;
            end
        end
        // explicit free has the last word
        if (free_valid) begin
            st_d.fl[free_slot] = FLAGS_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    grant_slot_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> !busy_q[req_slot]);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_grant && !req_deny));

    // R5
    halted_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && st_q.blk[req_tid]) |-> !req_grant);

    // R6
    free_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_valid |=> !busy_q[$past(free_slot)]);

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hold_chk
            // R8
            pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.fl[s].valid && st_q.fl[s].pend
                 && !(resp_valid && resp_slot == SLOT_W'(s))
                 && !(free_valid && free_slot == SLOT_W'(s)))
                |=> busy_q[s]);
        end
    endgenerate

endmodule

// File: tb/addr_inflight_tracker_tb.sv
module addr_inflight_tracker_tb;

    localparam int NS = 8;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0;
    logic [1:0]  req_tid = 0;
    logic [31:0] req_addr = 0;
    logic [15:0] req_seq = 0;
    logic        free_valid = 0;
    logic [2:0]  free_slot = 0;
    logic        issue_valid = 0;
    logic [2:0]  issue_slot = 0;
    logic        resp_valid = 0;
    logic [2:0]  resp_slot = 0;
    logic        tset = 0;
    logic [2:0]  tset_slot = 0;
    logic        tclr = 0;
    logic [2:0]  tclr_slot = 0;
    logic        kill_valid = 0;
    logic [1:0]  kill_tid = 0;
    logic [15:0] kill_seq = 0;
    logic        kill_ms = 0;
    logic        req_grant, req_deny;
    logic [2:0]  req_slot;

    logic        f_req_valid = 0;
    logic [31:0] f_req_addr = 0;
    logic        f_grant, f_deny;
    logic [2:0]  f_slot;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model of the table
    bit   mv[NS], mp[NS], mt[NS], ms[NS];
    int   mtid[NS], mseq[NS];
    logic [31:0] maddr[NS];
    bit   mblk[NT];

    always #10 clk = ~clk;

    addr_inflight_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_tid(req_tid), .req_addr(req_addr), .req_seq(req_seq),
        .req_grant(req_grant), .req_deny(req_deny), .req_slot(req_slot),
        .free_valid(free_valid), .free_slot(free_slot),
        .issue_valid(issue_valid), .issue_slot(issue_slot),
        .resp_valid(resp_valid), .resp_slot(resp_slot),
        .xstall_set(tset), .xstall_set_slot(tset_slot),
        .xstall_clr(tclr), .xstall_clr_slot(tclr_slot),
        .kill_valid(kill_valid), .kill_tid(kill_tid), .kill_seq(kill_seq), .kill_memstall(kill_ms)
    );

    addr_inflight_tracker #(.FETCH_PORT(1'b1)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .req_valid(f_req_valid), .req_tid(2'd0), .req_addr(f_req_addr), .req_seq(16'd0),
        .req_grant(f_grant), .req_deny(f_deny), .req_slot(f_slot),
        .free_valid(1'b0), .free_slot(3'd0),
        .issue_valid(1'b0), .issue_slot(3'd0),
        .resp_valid(1'b0), .resp_slot(3'd0),
        .xstall_set(1'b0), .xstall_set_slot(3'd0),
        .xstall_clr(1'b0), .xstall_clr_slot(3'd0),
        .kill_valid(1'b0), .kill_tid(2'd0), .kill_seq(16'd0), .kill_memstall(1'b0)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < NS; i++) begin
            mv[i] = 0; mp[i] = 0; mt[i] = 0; ms[i] = 0;
        end
        for (int t = 0; t < NT; t++) mblk[t] = 0;
    endfunction

    function automatic int exp_slot();
        for (int i = 0; i < NS; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_grant();
        if (!req_valid) return 0;
        if (mblk[req_tid]) return 0;
        for (int i = 0; i < NS; i++)
            if (mv[i] && mtid[i] == int'(req_tid) && maddr[i] == req_addr) return 0;
        return exp_slot() >= 0;
    endfunction

    function automatic void model_step(bit g, int gs);
        bit hit[NS];
        int bound = int'(kill_seq) + int'(kill_ms);
        for (int i = 0; i < NS; i++)
            hit[i] = kill_valid && mv[i] && mtid[i] == int'(kill_tid) && mseq[i] > bound;
        if (g) begin
            mv[gs] = 1; mp[gs] = 0; mt[gs] = 0; ms[gs] = 0;
            mtid[gs] = int'(req_tid); maddr[gs] = req_addr; mseq[gs] = int'(req_seq);
        end
        if (issue_valid && mv[issue_slot]) mp[issue_slot] = 1;
        if (tset && mv[tset_slot]) begin
            mt[tset_slot] = 1; mblk[mtid[tset_slot]] = 1;
        end
        if (resp_valid && mv[resp_slot]) begin
            mp[resp_slot] = 0;
            if (ms[resp_slot] && !mt[resp_slot]) begin
                mv[resp_slot] = 0; ms[resp_slot] = 0;
            end
        end
        if (tclr && mv[tclr_slot] && mt[tclr_slot]) begin
            mt[tclr_slot] = 0; mblk[mtid[tclr_slot]] = 0;
            if (ms[tclr_slot] && !mp[tclr_slot]) begin
                mv[tclr_slot] = 0; ms[tclr_slot] = 0;
            end
        end
        for (int i = 0; i < NS; i++) begin
            if (hit[i] && mv[i]) begin
                ms[i] = 1;
                if (mt[i]) mblk[mtid[i]] = 0;
                if (!mp[i] && !mt[i]) begin
                    mv[i] = 0; ms[i] = 0;
                end
            end
        end
        if (free_valid) begin
            mv[free_slot] = 0; mp[free_slot] = 0; mt[free_slot] = 0; ms[free_slot] = 0;
        end
    endfunction

    task automatic clear_inputs();
        req_valid = 0; free_valid = 0; issue_valid = 0; resp_valid = 0;
        tset = 0; tclr = 0; kill_valid = 0; kill_ms = 0; f_req_valid = 0;
    endtask

    // inputs are already set; check against model, then advance one clock
    task automatic cycle(string tag);
        bit g;
        int gs;
        #1;
        g  = exp_grant();
        gs = g ? exp_slot() : 0;
        check({tag, " grant"}, int'(req_grant), int'(g));
        check({tag, " deny"}, int'(req_deny), int'(req_valid && !g));
        check({tag, " slot"}, int'(req_slot), gs);
        @(posedge clk);
        model_step(g, gs);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic ask(string tag, int tid, int addr, int seq, bit eg, int es);
        req_valid = 1; req_tid = 2'(tid); req_addr = 32'(addr); req_seq = 16'(seq);
        #1;
        check({tag, " direct grant"}, int'(req_grant), int'(eg));
        check({tag, " direct slot"}, int'(req_slot), eg ? es : 0);
        cycle(tag);
    endtask

    task automatic do_reset();
        clear_inputs();
        rst_n = 0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        do_reset();

        // R1 reset state and first grant
        #1;
        check("R1 idle grant", int'(req_grant), 0);
        ask("R1", 0, 'h10, 5, 1, 0);
        ask("R3 same thread same addr", 0, 'h10, 6, 0, 0);
        ask("R3 other thread same addr", 1, 'h10, 7, 1, 1);
        for (int k = 0; k < 6; k++) ask("R2 fill", 2, k + 1, 8 + k, 1, k + 2);
        ask("R2 full", 3, 'hFF, 20, 0, 0);
        free_valid = 1; free_slot = 3'd2;
        ask("R6 free same cycle still full", 0, 'h77, 21, 0, 0);
        ask("R6 freed slot reused", 3, 'hFF, 22, 1, 2);

        // R6 free beats grant of the same slot
        do_reset();
        free_valid = 1; free_slot = 3'd0;
        ask("R6 grant with free", 0, 5, 1, 1, 0);
        ask("R6 slot left empty", 0, 5, 2, 1, 0);

        // R7 / R8 squash
        do_reset();
        ask("R7 setup", 1, 1, 10, 1, 0);
        ask("R7 setup", 1, 2, 20, 1, 1);
        ask("R7 setup", 1, 3, 30, 1, 2);
        ask("R7 setup", 2, 4, 40, 1, 3);
        issue_valid = 1; issue_slot = 3'd2; cycle("R8 issue");
        kill_valid = 1; kill_tid = 2'd1; kill_seq = 16'd15; cycle("R7 squash");
        ask("R7 younger idle row freed", 1, 2, 50, 1, 1);
        ask("R8 pending squashed row held", 1, 3, 51, 0, 0);
        ask("R7 older row kept", 1, 1, 52, 0, 0);
        resp_valid = 1; resp_slot = 3'd2; cycle("R8 response");
        ask("R8 response frees squashed row", 1, 3, 53, 1, 2);
        kill_valid = 1; kill_tid = 2'd2; kill_seq = 16'd39; kill_ms = 1; cycle("R7 memstall squash");
        ask("R7 stalling row survives", 2, 4, 60, 0, 0);
        kill_valid = 1; kill_tid = 2'd2; kill_seq = 16'd39; kill_ms = 0; cycle("R7 plain squash");
        ask("R7 row freed", 2, 4, 61, 1, 3);
        issue_valid = 1; issue_slot = 3'd0; cycle("R8 issue live");
        resp_valid = 1; resp_slot = 3'd0; cycle("R8 resp live");
        ask("R8 live row kept after response", 1, 1, 62, 0, 0);

        // R5 / R9 translation stall
        do_reset();
        ask("R5 setup", 0, 1, 1, 1, 0);
        tset = 1; tset_slot = 3'd0; cycle("R5 stall");
        ask("R5 halted thread", 0, 9, 2, 0, 0);
        ask("R5 other thread", 1, 9, 3, 1, 1);
        tclr = 1; tclr_slot = 3'd0; cycle("R5 release");
        ask("R5 released thread", 0, 9, 0, 1, 2);
        tset = 1; tset_slot = 3'd0; cycle("R9 stall again");
        kill_valid = 1; kill_tid = 2'd0; kill_seq = 16'd0; cycle("R9 squash");
        ask("R9 thread released", 0, 7, 4, 1, 3);
        ask("R9 stalled row held", 0, 1, 5, 0, 0);
        tclr = 1; tclr_slot = 3'd0; cycle("R9 stall end");
        ask("R9 row freed", 0, 1, 6, 1, 0);

        // R10 no wraparound
        do_reset();
        ask("R10 setup", 3, 1, 'hFFFF, 1, 0);
        ask("R10 setup", 3, 2, 0, 1, 1);
        kill_valid = 1; kill_tid = 2'd3; kill_seq = 16'hFFFF; kill_ms = 1; cycle("R10 top squash");
        ask("R10 seq 0 kept", 3, 2, 1, 0, 0);
        ask("R10 seq FFFF kept", 3, 1, 2, 0, 0);
        kill_valid = 1; kill_tid = 2'd3; kill_seq = 16'hFFFE; cycle("R10 squash");
        ask("R10 FFFF freed", 3, 1, 3, 1, 0);

        // R4 fetch side skips address check
        do_reset();
        f_req_valid = 1; f_req_addr = 32'h5; #1;
        check("R4 first fetch grant", int'(f_grant), 1);
        check("R4 first fetch slot", int'(f_slot), 0);
        @(posedge clk); @(negedge clk);
        f_req_valid = 1; f_req_addr = 32'h5; #1;
        check("R4 repeat fetch grant", int'(f_grant), 1);
        check("R4 repeat fetch slot", int'(f_slot), 1);
        @(posedge clk); @(negedge clk);
        clear_inputs();

        // random mix
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            req_valid  = ($urandom % 10) < 6;
            req_tid    = 2'($urandom % 4);
            req_addr   = 32'($urandom % 4);
            req_seq    = 16'($urandom % 64);
            free_valid = ($urandom % 10) < 2;  free_slot = 3'($urandom % 8);
            issue_valid = ($urandom % 10) < 3; issue_slot = 3'($urandom % 8);
            resp_valid = ($urandom % 4) == 0;  resp_slot = 3'($urandom % 8);
            tset       = ($urandom % 20) == 0; tset_slot = 3'($urandom % 8);
            tclr       = ($urandom % 7) == 0;  tclr_slot = 3'($urandom % 8);
            kill_valid = ($urandom % 20) == 0; kill_tid = 2'($urandom % 4);
            kill_seq   = 16'($urandom % 64);   kill_ms = 1'($urandom % 2);
            cycle("R2 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule